// File: doc/BRIEF.md
# Tag-Renaming Out-of-Order Operation Scheduler

This block accepts decoded arithmetic operations in program order and lets them finish in whatever order their operands and latencies allow. Each accepted operation lands in a waiting slot that belongs to one of two execution units: three slots feed an add/subtract unit and two feed a multiply/divide unit. At acceptance, every source register is looked up. A source that already holds its value has that value copied into the slot. A source that is still being produced is replaced by the producer's slot tag, so the register is renamed. The destination register is then marked as owned by the new slot.

A slot starts counting down its unit latency once both operands are present. When the count ends, the slot competes for one shared result bus. The bus carries the result together with the winning slot's tag. Every slot waiting on that tag, and every register still owned by it, captures the value in the same cycle. The winning slot is then released. A small register file can be preloaded and read back. The result bus is visible at the ports as a monitor.

Top module: `tag_sched`

## Requirements
- R1: After reset the block accepts any operation (iss_ready high), the result bus is idle and no register is marked pending.
- R2: Add (opcode 0) gives src1+src2 and subtract (opcode 1) gives src1-src2, both modulo 2^DW. When both operands are ready at acceptance, the result appears on the bus LAT_ADD+1 cycles after the cycle in which the operation was accepted.
- R3: Multiply (opcode 2) gives the low DW bits of the product after LAT_MUL+1 cycles. Divide (opcode 3) gives the unsigned quotient after LAT_DIV+1 cycles. Division by zero returns all ones.
- R4: An operation is accepted only when a slot of its unit is free. When both multiply/divide slots are busy, a multiply is refused while an add is still accepted. Each accepted operation occupies exactly one more slot.
- R5: A source produced by an in-flight operation takes the producer's tag. The consumer captures the broadcast value and starts its own latency count the cycle after the broadcast.
- R6: Completion may be out of order: a later short operation can broadcast before an earlier long one.
- R7: At most one result is broadcast per cycle. When several slots are ready together, the multiply/divide slots win over the add slots, and the lowest-numbered slot wins within a unit. A losing slot broadcasts in a later cycle. The broadcasting slot is busy during the broadcast and is free in the next cycle.
- R8: A register is updated from the bus only if it is still owned by the broadcasting tag. An older writer that finishes after a younger writer to the same register leaves the younger value in place.
- R9: An operation accepted in the same cycle as the broadcast of one of its source producers takes the broadcast value directly.
- R10: A register reads as pending from the cycle after an operation targeting it is accepted until its owning result is written.
- R11: Tags 1 to 3 name the add slots and tags 4 to 5 name the multiply/divide slots. Tag 0 means no producer. The lowest-numbered free slot of the needed unit is chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Operation offered |
| iss_ready | output | 1 | A slot of the needed unit is free |
| iss_op | input | 2 | 0 add, 1 sub, 2 mul, 3 div |
| iss_dst | input | 3 | Destination register |
| iss_src1 | input | 3 | First source register |
| iss_src2 | input | 3 | Second source register |
| ld_en | input | 1 | Preload a register value |
| ld_addr | input | 3 | Preload register index |
| ld_data | input | 16 | Preload value |
| rd_addr | input | 3 | Readback register index |
| rd_data | output | 16 | Readback register value |
| rd_pend | output | 1 | Readback register awaits a result |
| bus_valid | output | 1 | Result bus carries a result |
| bus_tag | output | 3 | Tag of the broadcasting slot |
| bus_data | output | 16 | Broadcast result |

## Verification
The hardest cases to reach from the ports are bus collisions and the same-cycle bypass at acceptance. Both need operations to become ready in exactly the same cycle. The stimulus creates a collision in two ways. It accepts an add exactly eight cycles after a multiply, so that both finish together. It also makes two adds wait on one multiply result, so that both start together. The bypass case is reached by accepting a dependent add exactly in the cycle in which its producer broadcasts. A write-after-write order is built with a slow divide and a fast add to the same register.

// File: rtl/tsched_pkg.sv
package tsched_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2,
    OP_DIV = 2'd3
  } op_e;
endpackage

// File: rtl/tsched_rs.sv
// One waiting slot: operand capture by tag, latency countdown, result compute.
module tsched_rs
  import tsched_pkg::*;
#(
  parameter int DW     = 16,
  parameter int TW     = 3,
  parameter bit IS_MUL = 1'b0,
  parameter int LAT_LO = 2,
  parameter int LAT_HI = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc,
  input  op_e           alloc_op,
  input  logic [DW-1:0] alloc_vj,
  input  logic [TW-1:0] alloc_qj,
  input  logic [DW-1:0] alloc_vk,
  input  logic [TW-1:0] alloc_qk,
  input  logic          bus_vld,
  input  logic [TW-1:0] bus_tag,
  input  logic [DW-1:0] bus_data,
  input  logic          grant,
  output logic          busy,
  output logic          req,
  output logic [DW-1:0] res
);
  localparam int LMAX = (LAT_HI > LAT_LO) ? LAT_HI : LAT_LO;
  localparam int CW   = $clog2(LMAX + 1);

  logic          busy_q, busy_d, go_q, go_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [TW-1:0] qj_q, qj_d, qk_q, qk_d;
  op_e           op_q, op_d;
  logic [DW-1:0] vj_q, vj_d, vk_q, vk_d;

  always_comb begin
    busy_d = busy_q; go_d = go_q; cnt_d = cnt_q;
    qj_d = qj_q; qk_d = qk_q; op_d = op_q; vj_d = vj_q; vk_d = vk_q;
    if (busy_q) begin
      if (bus_vld && qj_q != '0 && bus_tag == qj_q) begin
        vj_d = bus_data; qj_d = '0;
      end
      if (bus_vld && qk_q != '0 && bus_tag == qk_q) begin
        vk_d = bus_data; qk_d = '0;
      end
      if (!go_q && qj_q == '0 && qk_q == '0) begin
        go_d  = 1'b1;
        cnt_d = (op_q == OP_DIV) ? CW'(LAT_HI - 1) : CW'(LAT_LO - 1);
      end else if (go_q && cnt_q != '0) begin
        cnt_d = cnt_q - 1'b1;
      end
      if (grant) begin
        busy_d = 1'b0; go_d = 1'b0;
      end
    end
    if (alloc) begin
      busy_d = 1'b1; go_d = 1'b0; cnt_d = '0; op_d = alloc_op;
      vj_d = alloc_vj; qj_d = alloc_qj; vk_d = alloc_vk; qk_d = alloc_qk;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; go_q <= 1'b0; cnt_q <= '0; qj_q <= '0; qk_q <= '0;
    end else begin
      busy_q <= busy_d; go_q <= go_d; cnt_q <= cnt_d; qj_q <= qj_d; qk_q <= qk_d;
    end
  end

  always_ff @(posedge clk) begin
    op_q <= op_d; vj_q <= vj_d; vk_q <= vk_d;
  end

  assign busy = busy_q;
  assign req  = busy_q && go_q && (cnt_q == '0);

  generate
    if (IS_MUL) begin : g_mul
      always_comb begin
        if (op_q == OP_DIV) res = (vk_q == '0) ? '1 : vj_q / vk_q;
        else                res = DW'(vj_q * vk_q);
      end
    end else begin : g_add
      always_comb res = (op_q == OP_SUB) ? vj_q - vk_q : vj_q + vk_q;
    end
  endgenerate
endmodule

// File: rtl/tsched_arb.sv
// Fixed-priority bus grant: slots from FIRST upward win, then wrap to slot 0.
module tsched_arb #(
  parameter int N     = 5,
  parameter int FIRST = 3
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic found;
  always_comb begin
    gnt   = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (!found && req[(k + FIRST) % N]) begin
        found = 1'b1;
        gnt[(k + FIRST) % N] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tsched_regs.sv
// Register values plus owner tags; source lookup with same-cycle bus bypass.
module tsched_regs #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  parameter int TW   = 3,
  localparam int RW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_en,
  input  logic [RW-1:0]   ld_addr,
  input  logic [DW-1:0]   ld_data,
  input  logic            own_en,
  input  logic [RW-1:0]   own_reg,
  input  logic [TW-1:0]   own_tag,
  input  logic            bus_vld,
  input  logic [TW-1:0]   bus_tag,
  input  logic [DW-1:0]   bus_data,
  input  logic [RW-1:0]   s1_addr,
  input  logic [RW-1:0]   s2_addr,
  output logic [DW-1:0]   s1_val,
  output logic [TW-1:0]   s1_tag,
  output logic [DW-1:0]   s2_val,
  output logic [TW-1:0]   s2_tag,
  input  logic [RW-1:0]   rd_addr,
  output logic [DW-1:0]   rd_data,
  output logic [NREG-1:0] pend_vec
);
  logic [DW-1:0] val_q [NREG];
  logic [DW-1:0] val_d [NREG];
  logic [TW-1:0] own_q [NREG];
  logic [TW-1:0] own_d [NREG];

  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      val_d[r] = val_q[r];
      own_d[r] = own_q[r];
      if (bus_vld && own_q[r] != '0 && own_q[r] == bus_tag) begin
        val_d[r] = bus_data;
        own_d[r] = '0;
      end
    end
    if (ld_en)  val_d[ld_addr] = ld_data;
    if (own_en) own_d[own_reg] = own_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) for (int r = 0; r < NREG; r++) own_q[r] <= '0;
    else        for (int r = 0; r < NREG; r++) own_q[r] <= own_d[r];
  end

  always_ff @(posedge clk) begin
    for (int r = 0; r < NREG; r++) val_q[r] <= val_d[r];
  end

  always_comb begin
    s1_val = val_q[s1_addr]; s1_tag = own_q[s1_addr];
    if (s1_tag != '0 && bus_vld && bus_tag == s1_tag) begin
      s1_val = bus_data; s1_tag = '0;
    end
    s2_val = val_q[s2_addr]; s2_tag = own_q[s2_addr];
    if (s2_tag != '0 && bus_vld && bus_tag == s2_tag) begin
      s2_val = bus_data; s2_tag = '0;
    end
  end

  assign rd_data = val_q[rd_addr];
  always_comb for (int r = 0; r < NREG; r++) pend_vec[r] = (own_q[r] != '0);
endmodule

// File: rtl/tag_sched.sv
module tag_sched
  import tsched_pkg::*;
#(
  parameter int DW      = 16,
  parameter int NREG    = 8,
  parameter int NADD    = 3,
  parameter int NMUL    = 2,
  parameter int LAT_ADD = 2,
  parameter int LAT_MUL = 10,
  parameter int LAT_DIV = 40,
  localparam int NST    = NADD + NMUL,
  localparam int TW     = $clog2(NST + 1),
  localparam int RW     = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_valid,
  output logic          iss_ready,
  input  logic [1:0]    iss_op,
  input  logic [RW-1:0] iss_dst,
  input  logic [RW-1:0] iss_src1,
  input  logic [RW-1:0] iss_src2,
  input  logic          ld_en,
  input  logic [RW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic [RW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          rd_pend,
  output logic          bus_valid,
  output logic [TW-1:0] bus_tag,
  output logic [DW-1:0] bus_data
);
  logic [NST-1:0]  st_busy, st_req, st_gnt, st_alloc;
  logic [DW-1:0]   st_res [NST];
  logic [TW-1:0]   alloc_tag;
  logic            fire;
  logic [DW-1:0]   s1_val, s2_val;
  logic [TW-1:0]   s1_tag, s2_tag;
  logic [NREG-1:0] pend_vec;

  // lowest free slot of the unit that executes this opcode
  always_comb begin
    iss_ready = 1'b0;
    st_alloc  = '0;
    alloc_tag = '0;
    for (int i = 0; i < NST; i++) begin
      if (!iss_ready && !st_busy[i] && ((i >= NADD) == iss_op[1])) begin
        iss_ready   = 1'b1;
        st_alloc[i] = iss_valid;
        alloc_tag   = TW'(i + 1);
      end
    end
  end
  assign fire = iss_valid && iss_ready;

  tsched_arb #(.N(NST), .FIRST(NADD)) u_arb (.req(st_req), .gnt(st_gnt));

  always_comb begin
    bus_valid = |st_gnt;
    bus_tag   = '0;
    bus_data  = '0;
    for (int i = 0; i < NST; i++) begin
      if (st_gnt[i]) begin
        bus_tag  = TW'(i + 1);
        bus_data = st_res[i];
      end
    end
  end

  generate
    for (genvar i = 0; i < NST; i++) begin : g_st
      tsched_rs #(
        .DW(DW), .TW(TW), .IS_MUL(i >= NADD),
        .LAT_LO((i >= NADD) ? LAT_MUL : LAT_ADD),
        .LAT_HI((i >= NADD) ? LAT_DIV : LAT_ADD)
      ) u_rs (
        .clk(clk), .rst_n(rst_n),
        .alloc(st_alloc[i]), .alloc_op(op_e'(iss_op)),
        .alloc_vj(s1_val), .alloc_qj(s1_tag),
        .alloc_vk(s2_val), .alloc_qk(s2_tag),
        .bus_vld(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
        .grant(st_gnt[i]), .busy(st_busy[i]), .req(st_req[i]), .res(st_res[i])
      );
    end
  endgenerate

  tsched_regs #(.DW(DW), .NREG(NREG), .TW(TW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .own_en(fire), .own_reg(iss_dst), .own_tag(alloc_tag),
    .bus_vld(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
    .s1_addr(iss_src1), .s2_addr(iss_src2),
    .s1_val(s1_val), .s1_tag(s1_tag), .s2_val(s2_val), .s2_tag(s2_tag),
    .rd_addr(rd_addr), .rd_data(rd_data), .pend_vec(pend_vec)
  );

  assign rd_pend = pend_vec[rd_addr];
endmodule

// File: rtl/tag_sched_chk.sv
module tag_sched_chk #(
  parameter int NST  = 5,
  parameter int TW   = 3,
  parameter int NREG = 8,
  parameter int RW   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            iss_valid,
  input logic            iss_ready,
  input logic [RW-1:0]   iss_dst,
  input logic [NST-1:0]  busy,
  input logic [NREG-1:0] pend_vec,
  input logic            bus_valid,
  input logic [TW-1:0]   bus_tag
);
  AST_TAG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (bus_tag != '0 && int'(bus_tag) <= NST)); // R11

  AST_BCAST_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> busy[bus_tag - 1'b1]); // R7

  AST_FREE_AFTER_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |=> !busy[$past(bus_tag) - 1'b1]); // R7

  AST_ONE_SLOT_PER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready) |=>
      ($countones(busy) == $countones($past(busy)) + 1 - int'($past(bus_valid)))); // R4

  AST_DST_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready) |=> pend_vec[$past(iss_dst)]); // R10
endmodule

bind tag_sched tag_sched_chk #(.NST(NST), .TW(TW), .NREG(NREG), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
  .iss_dst(iss_dst), .busy(st_busy), .pend_vec(pend_vec),
  .bus_valid(bus_valid), .bus_tag(bus_tag)
);

// File: tb/tag_sched_tb.sv
`timescale 1ns/1ps
module tag_sched_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        iss_valid;
  logic        iss_ready;
  logic [1:0]  iss_op;
  logic [2:0]  iss_dst, iss_src1, iss_src2;
  logic        ld_en;
  logic [2:0]  ld_addr;
  logic [15:0] ld_data;
  logic [2:0]  rd_addr;
  logic [15:0] rd_data;
  logic        rd_pend;
  logic        bus_valid;
  logic [2:0]  bus_tag;
  logic [15:0] bus_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int nev = 0;
  int ev_tag  [32];
  int ev_data [32];
  int ev_cyc  [32];

  always #2 clk = ~clk;

  tag_sched u_dut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_op(iss_op), .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_pend(rd_pend),
    .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && bus_valid && nev < 32) begin
      ev_tag[nev]  = int'(bus_tag);
      ev_data[nev] = int'(bus_data);
      ev_cyc[nev]  = cyc;
      nev = nev + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_ev(input string req, input int i, input int tag, input int data, input int c);
    chk({req, " event tag"},   (i < nev) ? ev_tag[i]  : -1, tag);
    chk({req, " event data"},  (i < nev) ? ev_data[i] : -1, data);
    chk({req, " event cycle"}, (i < nev) ? ev_cyc[i]  : -1, c);
  endtask

  task automatic issue(input logic [1:0] op, input logic [2:0] d, input logic [2:0] a,
                       input logic [2:0] b, output int at);
    @(negedge clk);
    iss_valid = 1'b1; iss_op = op; iss_dst = d; iss_src1 = a; iss_src2 = b;
    #1;
    while (!iss_ready) begin @(negedge clk); #1; end
    at = cyc;
    @(posedge clk); #1;
    iss_valid = 1'b0;
  endtask

  task automatic load(input logic [2:0] a, input logic [15:0] v);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = a; ld_data = v;
    @(posedge clk); #1;
    ld_en = 1'b0;
  endtask

  task automatic preload();
    load(3'd0, 16'd0); load(3'd1, 16'd7); load(3'd2, 16'd5);
    load(3'd3, 16'd3); load(3'd4, 16'd0); load(3'd5, 16'd100);
    nev = 0;
  endtask

  task automatic peek(input logic [2:0] a, output int v, output int p);
    @(negedge clk);
    rd_addr = a; #1;
    v = int'(rd_data); p = int'(rd_pend);
  endtask

  task automatic drain();
    repeat (50) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    int v, p;
    chk("R1 ready", int'(iss_ready), 1);
    chk("R1 bus idle", int'(bus_valid), 0);
    for (int r = 0; r < 8; r++) begin
      rd_addr = 3'(r); #1;
      chk("R1 pending", int'(rd_pend), 0);
    end
  endtask

  task automatic t_addsub();
    int n, m, v, p;
    preload();
    issue(2'd0, 3'd6, 3'd1, 3'd2, n);
    issue(2'd1, 3'd7, 3'd2, 3'd1, m);
    drain();
    chk_ev("R2 add R11", 0, 1, 12, n + 3);
    chk_ev("R2 sub R11", 1, 2, 16'hFFFE, m + 3);
    peek(3'd6, v, p); chk("R2 add reg", v, 12); chk("R10 cleared", p, 0);
    peek(3'd7, v, p); chk("R2 sub reg", v, 16'hFFFE);
  endtask

  task automatic t_muldiv();
    int n, m, k, z;
    preload();
    issue(2'd2, 3'd6, 3'd1, 3'd2, n);
    issue(2'd3, 3'd7, 3'd5, 3'd3, m);
    issue(2'd0, 3'd0, 3'd1, 3'd3, k);
    drain();
    chk_ev("R6 add first", 0, 1, 10, k + 3);
    chk_ev("R3 mul", 1, 4, 35, n + 11);
    chk_ev("R3 div", 2, 5, 33, m + 41);
    nev = 0;
    issue(2'd3, 3'd6, 3'd1, 3'd4, z);
    drain();
    chk_ev("R3 div by zero", 0, 4, 16'hFFFF, z + 41);
  endtask

  task automatic t_stall();
    int n, m;
    preload();
    issue(2'd2, 3'd6, 3'd1, 3'd2, n);
    issue(2'd2, 3'd7, 3'd1, 3'd3, m);
    @(negedge clk);
    iss_op = 2'd2; #1;
    chk("R4 mul refused", int'(iss_ready), 0);
    iss_op = 2'd0; #1;
    chk("R4 add accepted", int'(iss_ready), 1);
    drain();
    chk("R4 both mul done", nev, 2);
  endtask

  task automatic t_raw();
    int n, a, b, v, p;
    preload();
    issue(2'd2, 3'd3, 3'd1, 3'd2, n);
    issue(2'd0, 3'd4, 3'd3, 3'd1, a);
    issue(2'd0, 3'd5, 3'd3, 3'd2, b);
    peek(3'd4, v, p); chk("R10 pending while waiting", p, 1);
    drain();
    chk_ev("R5 producer", 0, 4, 35, n + 11);
    chk_ev("R7 R5 low slot first", 1, 1, 42, n + 14);
    chk_ev("R7 R5 loser retries", 2, 2, 40, n + 15);
    peek(3'd4, v, p); chk("R5 reg", v, 42); chk("R10 cleared", p, 0);
    peek(3'd5, v, p); chk("R5 reg2", v, 40);
  endtask

  task automatic t_prio();
    int n, a;
    preload();
    issue(2'd2, 3'd6, 3'd1, 3'd2, n);
    repeat (7) @(negedge clk);
    issue(2'd0, 3'd7, 3'd1, 3'd3, a);
    drain();
    chk("R7 same ready cycle", a, n + 8);
    chk_ev("R7 mul wins", 0, 4, 35, n + 11);
    chk_ev("R7 add retries", 1, 1, 10, n + 12);
  endtask

  task automatic t_waw();
    int n, a, b, v, p;
    preload();
    issue(2'd3, 3'd6, 3'd5, 3'd3, n);
    issue(2'd0, 3'd6, 3'd1, 3'd2, a);
    issue(2'd0, 3'd7, 3'd6, 3'd1, b);
    repeat (6) @(posedge clk);
    peek(3'd6, v, p);
    chk("R8 young value", v, 12); chk("R10 owner cleared", p, 0);
    drain();
    chk_ev("R8 young first", 0, 1, 12, a + 3);
    chk_ev("R5 renamed consumer", 1, 2, 19, a + 6);
    chk_ev("R8 old late", 2, 4, 33, n + 41);
    peek(3'd6, v, p); chk("R8 old ignored", v, 12);
  endtask

  task automatic t_bypass();
    int n, a, v, p;
    preload();
    issue(2'd0, 3'd6, 3'd1, 3'd2, n);
    repeat (2) @(negedge clk);
    issue(2'd0, 3'd7, 3'd6, 3'd1, a);
    drain();
    chk("R9 accepted during bcast", a, n + 3);
    chk_ev("R9 producer", 0, 1, 12, n + 3);
    chk_ev("R9 bypass consumer", 1, 2, 19, a + 3);
    peek(3'd7, v, p); chk("R9 reg", v, 19);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; iss_valid = 1'b0; iss_op = '0; iss_dst = '0; iss_src1 = '0;
    iss_src2 = '0; ld_en = 1'b0; ld_addr = '0; ld_data = '0; rd_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_addsub();
    t_muldiv();
    t_stall();
    t_raw();
    t_prio();
    t_waw();
    t_bypass();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule